// File: doc/BRIEF.md
# Rotating Column-Order Frame Reader

This block pulls a square image that an upstream writer has already placed in external memory, and plays it out as a pixel stream turned 90 degrees clockwise. It walks the stored image one column at a time. Each column is read from its bottom row up to its top row. Every pixel is fetched with its own single-beat read on a simplified AXI4-style read channel. That channel has an address, a length and an address-valid going out, and an address-ready coming back. On the data side, data-valid and a 32-bit word come in, and data-ready goes out.

The block starts a frame only after a pulse from the write side says a stored frame is complete. While the memory-enable input is low it starts no new read request. Several reads may be in flight at once, up to a parameter limit. Returned words arrive in request order. The block unpacks the low 24 bits of each word into red, green and blue, and emits the pixel with start-of-line and start-of-frame markers. A downstream ready signal can stall the output. A stall propagates back as a deasserted data-ready. At the default size of 500 by 500 pixels, 4 bytes each, 60 frames per second, the read traffic is about 60 MB/s.

Top module: `rot_col_reader`

## Requirements
- R1: After reset, rd_avalid and pix_valid are 0.
- R2: No read address is presented until a frame_done pulse has been seen. After the last pixel of a frame is returned, the block stays idle with rd_avalid 0 until the next frame_done.
- R3: rd_avalid rises only at a clock edge at which mem_en was 1.
- R4: Once rd_avalid is 1 it stays 1, with rd_addr unchanged, until the cycle in which rd_aready is 1.
- R5: rd_len is always 1, meaning one beat per request.
- R6: With N = DIM, the k-th accepted request of a frame (k from 0) has address BASE + ((N-1-j)*N + i)*4, where i = k / N and j = k % N. Output row i therefore takes stored column i, bottom row first.
- R7: The number of accepted requests whose data has not yet been accepted never exceeds MAX_OUT. When data is withheld, exactly MAX_OUT requests are accepted.
- R8: rd_dready is 0 whenever pix_valid is 1 and pix_ready is 0. A word is taken only in a cycle with rd_dvalid and rd_dready both 1.
- R9: The output pixel carries pix_r = word[23:16], pix_g = word[15:8] and pix_b = word[7:0]. Bits 31:24 are discarded.
- R10: pix_sol is 1 exactly on the first pixel of each output row (k % N == 0). pix_sof is 1 exactly on pixel k = 0.
- R11: While pix_valid is 1 and pix_ready is 0, the pixel and its markers are held unchanged.
- R12: Each frame produces exactly N*N accepted requests and N*N output pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | input | 1 | Allows new read requests when 1 |
| frame_done | input | 1 | Write-side pulse: a stored frame is complete |
| rd_addr | output | ADDR_W | Byte address of the requested pixel |
| rd_len | output | LEN_W | Burst length, constant 1 |
| rd_avalid | output | 1 | Read address valid |
| rd_aready | input | 1 | Memory accepts the address |
| rd_data | input | 32 | Returned word, RGB in bits 23:0 |
| rd_dvalid | input | 1 | Returned word valid |
| rd_dready | output | 1 | Block can accept a returned word |
| pix_r | output | 8 | Red component |
| pix_g | output | 8 | Green component |
| pix_b | output | 8 | Blue component |
| pix_valid | output | 1 | Output pixel valid |
| pix_sol | output | 1 | First pixel of an output row |
| pix_sof | output | 1 | First pixel of the frame |
| pix_ready | input | 1 | Downstream accepts the pixel |

## Verification
Assertions check the channel rules on every cycle. These are: address-valid held with a stable address (R4), no request raised without the enable (R3), the in-flight bound (R7), the stall hold of the output (R11), and no request while idle (R2). The address sequence, the unpacking and the marker placement only show in the bench's scenarios, which compare each accepted address and each emitted pixel with a model of the rotated image (R6, R9, R10, R12). The exact saturation at MAX_OUT while memory withholds data also needs a scenario.

// File: rtl/rot_col_reader.sv
module rot_col_reader #(
  parameter int DIM = 500,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int MAX_OUT = 4,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              frame_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_avalid,
  input  logic              rd_aready,
  input  logic [31:0]       rd_data,
  input  logic              rd_dvalid,
  output logic              rd_dready,
  output logic [7:0]        pix_r,
  output logic [7:0]        pix_g,
  output logic [7:0]        pix_b,
  output logic              pix_valid,
  output logic              pix_sol,
  output logic              pix_sof,
  input  logic              pix_ready
);
  localparam int IDX_W = (DIM > 1) ? $clog2(DIM) : 1;
  localparam int CW = $clog2(MAX_OUT + 1) + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DIM - 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_OUT);

  logic pend, busy, req_done;
  logic [IDX_W-1:0] qi, qj, ri, rj;
  logic [CW-1:0] cnt, cnt_nx;
  logic [31:0] off;

  wire start  = !busy && pend;
  wire a_hs   = rd_avalid && rd_aready;
  wire d_hs   = rd_dvalid && rd_dready;
  wire q_last = (qi == LAST) && (qj == LAST);
  wire r_last = (ri == LAST) && (rj == LAST);
  wire more   = a_hs ? !q_last : !req_done;
  wire go     = busy && mem_en && more && (cnt_nx < LIMIT);
  wire unused_top = ^rd_data[31:24];

  assign cnt_nx    = cnt + CW'(a_hs) - CW'(d_hs);
  assign off       = ((32'(DIM - 1) - 32'(qj)) * 32'(DIM) + 32'(qi)) << 2;
  assign rd_addr   = BASE + ADDR_W'(off);
  assign rd_len    = LEN_W'(1);
  assign rd_dready = busy && (!pix_valid || pix_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      busy      <= 1'b0;
      req_done  <= 1'b0;
      qi        <= '0;
      qj        <= '0;
      ri        <= '0;
      rj        <= '0;
      cnt       <= '0;
      rd_avalid <= 1'b0;
    end else begin
      pend <= frame_done || (pend && !start);
      cnt  <= cnt_nx;
      if (start) begin
        busy     <= 1'b1;
        req_done <= 1'b0;
        qi       <= '0;
        qj       <= '0;
        ri       <= '0;
        rj       <= '0;
      end else begin
        if (a_hs) begin
          if (q_last) req_done <= 1'b1;
          if (qj == LAST) begin
            qj <= '0;
            qi <= qi + 1'b1;
          end else begin
            qj <= qj + 1'b1;
          end
        end
        if (d_hs) begin
          if (r_last) busy <= 1'b0;
          if (rj == LAST) begin
            rj <= '0;
            ri <= ri + 1'b1;
          end else begin
            rj <= rj + 1'b1;
          end
        end
      end
      if (!rd_avalid || a_hs) rd_avalid <= go;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_sol   <= 1'b0;
      pix_sof   <= 1'b0;
      pix_r     <= '0;
      pix_g     <= '0;
      pix_b     <= '0;
    end else if (d_hs) begin
      pix_valid <= 1'b1;
      pix_r     <= rd_data[23:16];
      pix_g     <= rd_data[15:8];
      pix_b     <= rd_data[7:0];
      pix_sol   <= (rj == '0);
      pix_sof   <= (ri == '0) && (rj == '0);
    end else if (pix_ready) begin
      pix_valid <= 1'b0;
    end
  end

  a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_avalid && !rd_aready |=> rd_avalid && $stable(rd_addr));

  a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_avalid) |-> $past(mem_en));

  a_r7_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable({pix_r, pix_g, pix_b, pix_sol, pix_sof}));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_avalid);
endmodule

// File: tb/sim_rot_col_reader.sv
module sim_rot_col_reader;
  localparam int N = 6;
  localparam int MAXO = 4;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0, mem_en = 1'b0, frame_done = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic [7:0] rd_len, pix_r, pix_g, pix_b;
  logic rd_avalid, rd_aready = 1'b0, rd_dvalid = 1'b0, rd_dready;
  logic pix_valid, pix_sol, pix_sof, pix_ready = 1'b0;

  always #4 clk = ~clk;

  rot_col_reader #(.DIM(N), .ADDR_W(32), .BASE(BASE), .MAX_OUT(MAXO), .LEN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .frame_done(frame_done),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_avalid(rd_avalid), .rd_aready(rd_aready),
    .rd_data(rd_data), .rd_dvalid(rd_dvalid), .rd_dready(rd_dready),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_valid(pix_valid),
    .pix_sol(pix_sol), .pix_sof(pix_sof), .pix_ready(pix_ready));

  int total = 0, fails = 0;
  int req_k = 0, pix_k = 0, outst = 0;
  logic [31:0] mq[$];
  logic [15:0] lfsr = 16'hACE1;
  // stimulus modes: 0 = random, 1 = always one, 2 = always zero
  int men_mode = 2, ar_mode = 2, dv_mode = 2, pr_mode = 1;
  bit fd_req = 0;
  bit prev_av = 0, prev_ar = 0, prev_men = 0, prev_pv = 0, prev_pr = 0;
  logic [31:0] prev_addr = '0;
  logic [28:0] prev_pix = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [7:0] x;
    x = a[9:2];
    return {~x, x ^ 8'h3C, x + 8'd17, x * 8'd5 + 8'd1};
  endfunction

  function automatic logic [31:0] exp_addr(input int k);
    int i, j;
    i = k / N;
    j = k % N;
    return BASE + 32'(((N - 1 - j) * N + i) * 4);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pick(input int mode, input int bitn);
    if (mode == 1) return 1'b1;
    if (mode == 2) return 1'b0;
    return lfsr[bitn] | lfsr[bitn + 3];
  endfunction

  task automatic step();
    logic [31:0] w;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rd_avalid && !prev_av)
      check(prev_men, "R3 avalid rose without mem_en", 64'(prev_men), 64'd1);
    if (prev_av && !prev_ar)
      check(rd_avalid && rd_addr == prev_addr, "R4 address hold", 64'(rd_addr), 64'(prev_addr));
    if (prev_pv && !prev_pr)
      check(pix_valid && {pix_r, pix_g, pix_b, pix_sol, pix_sof} == prev_pix, "R11 stall hold",
            64'({pix_r, pix_g, pix_b, pix_sol, pix_sof}), 64'(prev_pix));
    mem_en     = pick(men_mode, 1);
    rd_aready  = pick(ar_mode, 2);
    pix_ready  = pick(pr_mode, 5);
    frame_done = fd_req;
    fd_req     = 0;
    rd_dvalid  = (mq.size() > 0) && pick(dv_mode, 7);
    rd_data    = (mq.size() > 0) ? mem_word(mq[0]) : 32'hDEAD_BEEF;
    #1;
    if (rd_avalid && rd_aready) begin
      check(rd_addr == exp_addr(req_k), "R6 request address", 64'(rd_addr), 64'(exp_addr(req_k)));
      check(rd_len == 8'd1, "R5 burst length", 64'(rd_len), 64'd1);
      check(req_k < N * N, "R12 requests per frame", 64'(req_k + 1), 64'(N * N));
      mq.push_back(rd_addr);
      req_k++;
      outst++;
    end
    if (rd_dvalid && rd_dready) begin
      void'(mq.pop_front());
      outst--;
    end
    if (rd_avalid && rd_aready)
      check(outst <= MAXO, "R7 in-flight bound", 64'(outst), 64'(MAXO));
    if (pix_valid && !pix_ready)
      check(!rd_dready, "R8 dready during stall", 64'(rd_dready), 64'd0);
    if (pix_valid && pix_ready) begin
      w = mem_word(exp_addr(pix_k));
      check({pix_r, pix_g, pix_b} == w[23:0], "R9 pixel unpack",
            64'({pix_r, pix_g, pix_b}), 64'(w[23:0]));
      check(pix_sol == (pix_k % N == 0), "R10 start-of-line", 64'(pix_sol), 64'(pix_k % N == 0));
      check(pix_sof == (pix_k == 0), "R10 start-of-frame", 64'(pix_sof), 64'(pix_k == 0));
      pix_k++;
    end
    prev_av = rd_avalid; prev_ar = rd_aready; prev_men = mem_en;
    prev_pv = pix_valid; prev_pr = pix_ready; prev_addr = rd_addr;
    prev_pix = {pix_r, pix_g, pix_b, pix_sol, pix_sof};
  endtask

  task automatic finish_frame(input string tag);
    for (int c = 0; c < 20000 && pix_k < N * N; c++) step();
    check(pix_k == N * N, {tag, " R12 pixels per frame"}, 64'(pix_k), 64'(N * N));
    for (int c = 0; c < 30; c++) begin
      step();
      if (rd_avalid) check(0, {tag, " R2 idle after frame"}, 64'd1, 64'd0);
    end
    check(req_k == N * N, {tag, " R12 requests per frame"}, 64'(req_k), 64'(N * N));
    req_k = 0;
    pix_k = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!rd_avalid, "R1 reset avalid", 64'(rd_avalid), 64'd0);
    check(!pix_valid, "R1 reset pix_valid", 64'(pix_valid), 64'd0);
    rst_n = 1'b1;
    // R2: enabled memory but no frame_done
    men_mode = 1; ar_mode = 1;
    for (int c = 0; c < 20; c++) begin
      step();
      if (rd_avalid) check(0, "R2 request before frame_done", 64'd1, 64'd0);
    end
    check(!rd_avalid, "R2 quiet before frame_done", 64'(rd_avalid), 64'd0);
    // R3: frame armed but memory disabled
    men_mode = 2;
    fd_req = 1;
    for (int c = 0; c < 20; c++) begin
      step();
      if (rd_avalid) check(0, "R3 request while disabled", 64'd1, 64'd0);
    end
    check(req_k == 0, "R3 no request while disabled", 64'(req_k), 64'd0);
    // frame 1: random enable, ready and valid patterns
    men_mode = 0; ar_mode = 0; dv_mode = 0; pr_mode = 0;
    finish_frame("frame1");
    // frame 2: memory withholds data, in-flight must saturate at MAX_OUT
    men_mode = 1; ar_mode = 1; dv_mode = 2; pr_mode = 1;
    fd_req = 1;
    for (int c = 0; c < 30; c++) step();
    check(req_k == MAXO, "R7 saturation at MAX_OUT", 64'(req_k), 64'(MAXO));
    dv_mode = 1;
    finish_frame("frame2");
    // frame 3: full throughput with a stalling sink
    dv_mode = 0; pr_mode = 0; ar_mode = 1;
    fd_req = 1;
    finish_frame("frame3");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule